// File: doc/BRIEF.md
# Latched LED Matrix Row Scanner

This block refreshes a multiplexed red/green LED matrix panel. It reads pixel levels from a frame buffer that it addresses itself, and sends one row of column bits at a time into an external chain of shift registers. That chain has output latches. The block generates the shift clock and serial data line, then fires a one-cycle strobe that copies the loaded row to the column drivers. It also drives a binary row number for external row decoders and an active-high output enable.

The column outputs are latched, so the serial load of the next row runs while the current row is lit. A row's lit time therefore comes only from an internal timer. It does not depend on the shift rate.

Each colour of each pixel has a 2-bit level. The block shows that level with two weighted sub-frames. The whole panel is first scanned with the level's low bit at one unit of on-time, then scanned again with the high bit at two units. This gives four shades: off, about a third, about two thirds and full. The refresh rate is set by the per-row time input and the shift-clock divisor input. Both inputs are meant to be held steady while the block runs.

Top module: `led_row_scan`

## Requirements
- R1: While reset is low, and in the cycle after it is released, `col_oe`, `col_strobe` and `dark_miss` are 0, and `row_sel` is 0. `shift_clk` is 0 during reset.
- R2: Each shift-clock high phase and each low phase lasts `half_period` system cycles. `shift_data` holds steady for the whole high phase.
- R3: `col_strobe` is a single-cycle pulse. It occurs only while `shift_clk` and `col_oe` are both low. Exactly 90 shift-clock rising edges happen between reset and the first strobe, and between any two strobes.
- R4: Rows are lit in this order: rows 0 to 15 of the low sub-frame, then rows 0 to 15 of the high sub-frame, then the order repeats. When `col_oe` rises, `row_sel` names the row whose data is in the latches.
- R5: `col_oe` stays high for exactly `row_time` cycles per row in the low sub-frame, and for exactly 2×`row_time` cycles in the high sub-frame.
- R6: `row_sel` changes only while `col_oe` is low, and only if `col_oe` was also low in the previous cycle. Between two lit rows, `col_oe` is low for at least `BLANK` cycles.
- R7: The chain holds 90 bits. After a strobe, latch bit 2c+1 is the red bit and latch bit 2c is the green bit of column c. The first bit shifted is bit 89. In sub-frame s (0 = low, 1 = high), the bit sent is bit s of that colour's level. `fb_pix[3:2]` is the red level and `fb_pix[1:0]` is the green level of the pixel at (`fb_row`, `fb_col`). The frame buffer returns the pixel combinationally.
- R8: If a load ends before the row timer expires, the next row lights exactly `BLANK` cycles after the previous row goes dark.
- R9: If the row timer expires before the next load is complete, `dark_miss` goes to 1 and stays at 1 until reset. `col_oe` stays low until the load is finished. The row order of R4 then continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_period | input | 8 | Shift-clock phase length in system cycles (minimum 1) |
| row_time | input | 20 | Low sub-frame on-time per row, in system cycles |
| fb_row | output | 4 | Frame buffer row address |
| fb_col | output | 6 | Frame buffer column address |
| fb_pix | input | 4 | Pixel levels: [3:2] red, [1:0] green |
| shift_clk | output | 1 | Serial clock to the column chain |
| shift_data | output | 1 | Serial data, changes while `shift_clk` is low |
| col_strobe | output | 1 | Latch transfer pulse |
| row_sel | output | 4 | Binary row number for the row decoders |
| col_oe | output | 1 | Column output enable, active high |
| dark_miss | output | 1 | Sticky flag: load not complete when the row timer expired |

## Verification
The bench rebuilds the column chain from the ports. It shifts `shift_data` on every observed `shift_clk` rise and copies the chain on the strobe cycle. It then compares the copy with the pattern it computes for the expected row and sub-frame when `col_oe` rises. All sampling happens on the falling clock edge, so each registered output is read half a cycle after the edge that set it. The bench makes no assumption about the fixed delay to the first strobe. Instead, each check is tied to an observed event: a shift-clock fall closes the high-phase length check, the strobe closes the bit-count check, a `col_oe` rise starts the on-time count and closes the blank-gap count, and a `col_oe` fall closes the on-time check against `row_time` or twice that value. The underrun flag is sampled at the first lit row, and again after several rows once the timer is shorter than the load.

// File: rtl/led_row_scan.sv
`timescale 1ns/1ps
module led_row_scan #(
  parameter int COLS   = 45,
  parameter int ROWS   = 16,
  parameter int DIV_W  = 8,
  parameter int TIME_W = 20,
  parameter int BLANK  = 2,
  localparam int NBITS = 2 * COLS,
  localparam int BIT_W = $clog2(NBITS),
  localparam int COL_W = BIT_W - 1,
  localparam int ROW_W = $clog2(ROWS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_period,
  input  logic [TIME_W-1:0] row_time,
  output logic [ROW_W-1:0]  fb_row,
  output logic [COL_W-1:0]  fb_col,
  input  logic [3:0]        fb_pix,
  output logic              shift_clk,
  output logic              shift_data,
  output logic              col_strobe,
  output logic [ROW_W-1:0]  row_sel,
  output logic              col_oe,
  output logic              dark_miss
);
  localparam int BC_W = $clog2(BLANK + 1);

  typedef enum logic [1:0] {S_WAIT, S_BLANK, S_ON} scan_t;

  scan_t             state;
  logic [BC_W-1:0]   bcnt;
  logic [TIME_W:0]   tmr;
  logic              sub_q;

  logic              busy;
  logic [BIT_W-1:0]  bidx;
  logic [DIV_W-1:0]  dcnt;
  logic              sclk_q;
  logic [ROW_W-1:0]  lrow;
  logic              lsub;

  logic latch_now, half_tick;

  assign latch_now  = (state == S_BLANK) && (bcnt == '0);
  assign half_tick  = ({1'b0, dcnt} + 1'b1) >= {1'b0, half_period};
  assign fb_row     = lrow;
  assign fb_col     = bidx[BIT_W-1:1];
  assign shift_data = busy && fb_pix[{bidx[0], lsub}];
  assign shift_clk  = sclk_q;
  assign col_strobe = latch_now;
  assign col_oe     = (state == S_ON);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b1;
      bidx   <= BIT_W'(NBITS - 1);
      dcnt   <= '0;
      sclk_q <= 1'b0;
      lrow   <= '0;
      lsub   <= 1'b0;
    end else if (latch_now) begin
      busy   <= 1'b1;
      bidx   <= BIT_W'(NBITS - 1);
      dcnt   <= '0;
      sclk_q <= 1'b0;
      if (lrow == ROW_W'(ROWS - 1)) begin
        lrow <= '0;
        lsub <= ~lsub;
      end else begin
        lrow <= lrow + 1'b1;
      end
    end else if (busy) begin
      if (half_tick) begin
        dcnt <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
        end else begin
          sclk_q <= 1'b0;
          if (bidx == '0) busy <= 1'b0;
          else            bidx <= bidx - 1'b1;
        end
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_WAIT;
      bcnt      <= '0;
      tmr       <= '0;
      row_sel   <= '0;
      sub_q     <= 1'b0;
      dark_miss <= 1'b0;
    end else begin
      case (state)
        S_WAIT: begin
          if (!busy) begin
            state <= S_BLANK;
            bcnt  <= '0;
          end
        end
        S_BLANK: begin
          if (bcnt == '0) begin
            row_sel <= lrow;
            sub_q   <= lsub;
          end
          if (bcnt == BC_W'(BLANK - 1)) begin
            state <= S_ON;
            tmr   <= sub_q ? {row_time, 1'b0} : {1'b0, row_time};
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        default: begin
          if (tmr <= 1) begin
            bcnt <= '0;
            if (busy) begin
              dark_miss <= 1'b1;
              state     <= S_WAIT;
            end else begin
              state <= S_BLANK;
            end
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/led_row_scan_chk.sv
`timescale 1ns/1ps
module led_row_scan_chk #(
  parameter int NBITS = 90,
  parameter int ROW_W = 4
)(
  input logic             clk,
  input logic             rst_n,
  input logic             shift_clk,
  input logic             shift_data,
  input logic             col_strobe,
  input logic             col_oe,
  input logic [ROW_W-1:0] row_sel,
  input logic             dark_miss
);
  localparam int CW = $clog2(NBITS + 2);
  logic [CW-1:0] rises;
  logic          sclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rises  <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_d <= shift_clk;
      if (col_strobe)               rises <= '0;
      else if (shift_clk && !sclk_d) rises <= rises + 1'b1;
    end
  end

  AST_STROBE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    col_strobe |-> (!col_oe && !shift_clk)); // R3
  AST_STROBE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    col_strobe |-> (rises == CW'(NBITS))); // R3
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    col_strobe |=> !col_strobe); // R3
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_clk && $past(shift_clk)) |-> $stable(shift_data)); // R2
  AST_ROW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (row_sel != $past(row_sel)) |-> (!col_oe && !$past(col_oe))); // R6
  AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dark_miss) |-> dark_miss); // R9
endmodule

bind led_row_scan led_row_scan_chk #(.NBITS(2 * COLS), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .shift_data(shift_data),
  .col_strobe(col_strobe), .col_oe(col_oe), .row_sel(row_sel), .dark_miss(dark_miss)
);

// File: tb/sim_led_row_scan.sv
`timescale 1ns/1ps
module sim_led_row_scan;
  localparam int COLS = 45, ROWS = 16, NB = 90, BLANK = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [7:0]  half = 8'd1;
  logic [19:0] rt = 20'd300;
  logic [3:0]  fb_row;
  logic [5:0]  fb_col;
  logic [3:0]  fb_pix;
  logic        shift_clk, shift_data, col_strobe, col_oe, dark_miss;
  logic [3:0]  row_sel;
  logic [3:0]  fb [ROWS][COLS];

  assign fb_pix = (fb_col < 6'(COLS)) ? fb[fb_row][fb_col] : 4'h0;

  led_row_scan #(.COLS(COLS), .ROWS(ROWS), .DIV_W(8), .TIME_W(20), .BLANK(BLANK)) u0 (
    .clk(clk), .rst_n(rst_n), .half_period(half), .row_time(rt),
    .fb_row(fb_row), .fb_col(fb_col), .fb_pix(fb_pix),
    .shift_clk(shift_clk), .shift_data(shift_data), .col_strobe(col_strobe),
    .row_sel(row_sel), .col_oe(col_oe), .dark_miss(dark_miss));

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] pat(input int r, input int s);
    logic [NB-1:0] v;
    logic [3:0] p;
    for (int k = 0; k < NB; k++) begin
      p = fb[r][k/2];
      v[k] = p[(k%2)*2 + s];
    end
    return v;
  endfunction

  bit prev_sclk, prev_oe, hold, stable_ok, gap_exact = 1'b1, miss_exp = 1'b0;
  int hi_len, rises, on_len, gap, disp_n, exp_row, exp_sub, cur_sub;
  logic [NB-1:0] sr, latched;
  logic [3:0] prev_row;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (R1..R9 run): actual cycle %0d expected below 190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sclk = 0; prev_oe = 0; hi_len = 0; rises = 0; on_len = 0; gap = 0;
      disp_n = 0; exp_row = 0; exp_sub = 0; cur_sub = 0; sr = '0; latched = '0;
      prev_row = 0; stable_ok = 1; hold = 0;
    end else begin
      if (shift_clk && !prev_sclk) begin
        sr = {sr[NB-2:0], shift_data}; rises++; hi_len = 1; hold = shift_data; stable_ok = 1;
      end else if (shift_clk) begin
        hi_len++;
        if (shift_data !== hold) stable_ok = 0;
      end else if (prev_sclk) begin
        check("R2 high phase length", 96'(hi_len), 96'(half));
        check("R2 data steady while high", 96'(stable_ok), 96'd1);
      end
      if (col_strobe) begin
        check("R3 bits per strobe", 96'(rises), 96'(NB));
        check("R3 strobe while dark", {94'd0, col_oe, shift_clk}, 96'd0);
        latched = sr; rises = 0;
      end
      if (col_oe && !prev_oe) begin
        check("R4 row order", 96'(row_sel), 96'(exp_row));
        check("R7 latched column pattern", 96'(latched), 96'(pat(exp_row, exp_sub)));
        if (disp_n > 0) begin
          if (gap_exact) check("R8 overlap gap", 96'(gap), 96'(BLANK));
          else           check("R6 blank gap", 96'(gap >= BLANK), 96'd1);
        end
        if (!miss_exp) check("R9 no underrun", 96'(dark_miss), 96'd0);
        cur_sub = exp_sub; on_len = 1;
      end else if (col_oe) begin
        on_len++;
        check("R6 row steady while lit", 96'(row_sel), 96'(prev_row));
      end
      if (!col_oe && prev_oe) begin
        check("R5 on-time", 96'(on_len), 96'(rt) << cur_sub);
        gap = 1; disp_n++;
        if (exp_row == ROWS - 1) begin exp_row = 0; exp_sub = 1 - exp_sub; end
        else exp_row++;
      end else if (!col_oe) begin
        gap++;
      end
      prev_sclk = shift_clk; prev_oe = col_oe; prev_row = row_sel;
    end
  end

  task automatic do_reset(input logic [7:0] h, input logic [19:0] t);
    rst_n = 1'b0; half = h; rt = t;
    repeat (4) @(negedge clk);
    check("R1 outputs in reset", {91'd0, col_oe, col_strobe, shift_clk, dark_miss, |row_sel}, 96'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after release", {92'd0, col_oe, col_strobe, dark_miss, |row_sel}, 96'd0);
  endtask

  task automatic wait_rows(input int n);
    while (disp_n < n) @(negedge clk);
  endtask

  task automatic t_reset_state;
    for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) fb[r][c] = 4'h0;
    do_reset(8'd1, 20'd300);
    repeat (50) @(negedge clk);
    check("R1 dark during first load", 96'(col_oe), 96'd0);
  endtask

  task automatic t_full_frame;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        fb[r][c] = 4'(((((r + c) % 4)) << 2) | ((r * 3 + c) % 4));
    gap_exact = 1'b1; miss_exp = 1'b0;
    do_reset(8'd1, 20'd300);
    wait_rows(33);
    check("R9 flag clear after full frames", 96'(dark_miss), 96'd0);
  endtask

  task automatic t_slow_shift;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        fb[r][c] = ((r + c) % 2 == 0) ? 4'hF : 4'(c % 3);
    gap_exact = 1'b1; miss_exp = 1'b0;
    do_reset(8'd3, 20'd600);
    wait_rows(20);
    check("R7 R8 slow shift no underrun", 96'(dark_miss), 96'd0);
  endtask

  task automatic t_underrun;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        fb[r][c] = 4'((r * 5 + c * 7) % 16);
    gap_exact = 1'b0; miss_exp = 1'b0;
    do_reset(8'd4, 20'd100);
    wait_rows(1);
    miss_exp = 1'b1;
    wait_rows(6);
    check("R9 underrun flag raised", 96'(dark_miss), 96'd1);
    repeat (30) @(negedge clk);
    check("R9 underrun flag sticky", 96'(dark_miss), 96'd1);
    miss_exp = 1'b0; gap_exact = 1'b1;
    do_reset(8'd1, 20'd300);
    check("R1 R9 flag cleared by reset", 96'(dark_miss), 96'd0);
  endtask

  initial begin
    t_reset_state;
    t_full_frame;
    t_slow_shift;
    t_underrun;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule